// File: doc/BRIEF.md
# One-pass CRC frame checker

This block sits on the receive side of a byte-wide link. It verifies frames that carry a trailing CRC field. Every valid byte from the start-of-frame marker through the end-of-frame marker goes through one reflected CRC update. This includes the bytes of the CRC field itself. The checker never has to find where the data stops and the field starts. When the end-of-frame byte has been absorbed, the running register is compared with a fixed residue. The result is reported as a one-cycle done strobe with a pass flag.

The default settings give a 32-bit reflected CRC with generator 0xEDB88320 and an all-ones preset. The sender inverts the CRC before appending it. Under these settings a clean frame leaves 0xDEBB20E3 in the register, and that value is the default residue. If the sender does not invert, the residue is zero, whatever preset value is used.

Bytes arrive least significant bit first. The appended CRC field is sent low byte first.

Top module: `one_pass_crc_checker`

## Requirements
- R1: After reset, `chk_done` and `chk_ok` are low, and they stay low until an end-of-frame byte is absorbed.
- R2: The default settings are generator 0xEDB88320 (reflected), preset all-ones and residue 0xDEBB20E3. Under them, a frame made of N data bytes followed by the four bytes of the inverted CRC, low byte first, gives `chk_ok`=1 with the strobe. Examples are the bytes "123456789" followed by 26 39 F4 CB, and an empty message followed by 00 00 00 00.
- R3: A frame with any data or CRC byte altered gives `chk_done`=1 with `chk_ok`=0. `chk_ok` is never high without `chk_done`.
- R4: `chk_done` is high for exactly the one cycle after the clock edge that absorbs a valid end-of-frame byte.
- R5: Cycles with `in_valid` low leave the running state untouched, so gaps inside a frame do not change the verdict.
- R6: A valid byte with `in_sof` high restarts the register from the preset, even when the previous frame never saw its end-of-frame byte.
- R7: Valid bytes that arrive while no frame is open and without `in_sof` are ignored. If such a byte carries `in_eof`, no strobe follows, and the next frame is judged as if the stray bytes had never arrived.
- R8: With the all-ones preset, a frame whose CRC was computed over the message alone but which arrives with a zero byte prepended fails.
- R9: With the default final inversion, a good frame that has a zero byte appended after its CRC field (end-of-frame moved onto that byte) fails.
- R10: With `RESIDUE`=0 and a sender that appends the CRC without inversion, a good frame passes for a non-trivial preset (0x5A5A0F0F) and a corrupted one fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on `in_data` this cycle |
| in_sof | input | 1 | The byte is the first of a frame |
| in_eof | input | 1 | The byte is the last of a frame (last CRC byte) |
| in_data | input | 8 | Received byte, bit 0 first on the wire |
| chk_done | output | 1 | One-cycle verdict strobe |
| chk_ok | output | 1 | Frame passed; meaningful only with `chk_done` |

## Verification
Some corner cases go after the frame boundary bookkeeping.
- A new start-of-frame arrives in the middle of an unfinished frame. A design that did not reload the preset would fail the clean frame that follows.
- Stray bytes, including a stray end-of-frame byte, arrive between frames. A design that absorbed them would strobe without a frame, or would corrupt the next result.
- Idle gaps occur inside a frame. A design that updated on idle cycles would reject good frames.

Other cases check that the residue is right.
- Empty and one-byte messages, and a known string with its published check value, expose a wrong residue or a wrong bit order.
- A zero byte is prepended or appended. A design whose preset or residue assumed no inversion would accept these frames.

A second instance with a zero residue confirms that the compare constant, not the update, sets the pass condition.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    PH_CLOSED = 1'b0,
    PH_OPEN   = 1'b1
  } frame_ph_t;
endpackage

// File: rtl/crc_chk_update.sv
module crc_chk_update #(
  parameter int              CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]               cur_i,
  input  logic [crc_chk_pkg::BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]               nxt_o
);
  localparam int BW = crc_chk_pkg::BYTE_W;

  // Reflected byte update: fold the byte into the low end, then divide
  // one bit per step, shifting toward bit 0.
  function automatic logic [CRC_W-1:0] step_byte(input logic [CRC_W-1:0] c,
                                                 input logic [BW-1:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-BW){1'b0}}, d};
    for (int k = 0; k < BW; k++) begin
      r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    end
    return r;
  endfunction

  assign nxt_o = step_byte(cur_i, data_i);
endmodule

// File: rtl/crc_chk_track.sv
module crc_chk_track #(
  parameter int               CRC_W  = 32,
  parameter logic [CRC_W-1:0] PRESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [CRC_W-1:0] nxt_i,
  output logic [CRC_W-1:0] base_o,
  output logic             open_o,
  output logic             eof_take_o
);
  import crc_chk_pkg::*;

  frame_ph_t        phase;
  logic [CRC_W-1:0] crc_q;
  logic             take;

  // A byte counts when it opens a frame or belongs to an open one.
  assign take       = in_valid & (in_sof | (phase == PH_OPEN));
  assign eof_take_o = take & in_eof;
  assign base_o     = in_sof ? PRESET : crc_q;
  assign open_o     = (phase == PH_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_CLOSED;
      crc_q <= PRESET;
    end else if (take) begin
      crc_q <= nxt_i;
      phase <= in_eof ? PH_CLOSED : PH_OPEN;
    end
  end

  // R5: idle cycles leave the state alone
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(crc_q) && $stable(phase)));

  // R7: with no frame open and no start, the register does not move
  a_r7_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_CLOSED) && !(in_valid && in_sof)) |=> $stable(crc_q));
endmodule

// File: rtl/crc_chk_verdict.sv
module crc_chk_verdict #(
  parameter int               CRC_W   = 32,
  parameter logic [CRC_W-1:0] RESIDUE = 32'hDEBB20E3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof_take_i,
  input  logic [CRC_W-1:0] nxt_i,
  output logic             done_o,
  output logic             ok_o
);
  logic match;
  assign match = (nxt_i == RESIDUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      ok_o   <= 1'b0;
    end else begin
      done_o <= eof_take_i;
      ok_o   <= eof_take_i & match;
    end
  end

  // R4: every strobe answers an absorbed end-of-frame byte
  a_r4_strobe_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(eof_take_i));

  // R3: a pass flag never appears without the strobe
  a_r3_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> done_o);
endmodule

// File: rtl/one_pass_crc_checker.sv
module one_pass_crc_checker #(
  parameter int               CRC_W   = 32,
  parameter logic [CRC_W-1:0] POLY    = 32'hEDB88320,
  parameter logic [CRC_W-1:0] PRESET  = '1,
  parameter logic [CRC_W-1:0] RESIDUE = 32'hDEBB20E3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic                             in_sof,
  input  logic                             in_eof,
  input  logic [crc_chk_pkg::BYTE_W-1:0]   in_data,
  output logic                             chk_done,
  output logic                             chk_ok
);
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] nxt;
  logic             frame_open;
  logic             eof_take;

  crc_chk_update #(.CRC_W(CRC_W), .POLY(POLY)) u_upd (
    .cur_i  (base),
    .data_i (in_data),
    .nxt_o  (nxt)
  );

  crc_chk_track #(.CRC_W(CRC_W), .PRESET(PRESET)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .nxt_i      (nxt),
    .base_o     (base),
    .open_o     (frame_open),
    .eof_take_o (eof_take)
  );

  crc_chk_verdict #(.CRC_W(CRC_W), .RESIDUE(RESIDUE)) u_vrd (
    .clk        (clk),
    .rst_n      (rst_n),
    .eof_take_i (eof_take),
    .nxt_i      (nxt),
    .done_o     (chk_done),
    .ok_o       (chk_ok)
  );

  // R7: a stray end-of-frame byte outside any frame raises no strobe
  a_r7_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof && !in_sof && !frame_open) |=> !chk_done);
endmodule

// File: tb/sim_one_pass_crc_checker.sv
`timescale 1ns/1ps
module sim_one_pass_crc_checker;
  localparam real TCK = 8.0;
  localparam logic [31:0] RPOLY = 32'hEDB88320;
  localparam logic [31:0] ALT_PRESET = 32'h5A5A0F0F;

  // {data length, seed, flip index (FF = none), expected pass}
  localparam logic [31:0] VECS [0:7] = '{
    {8'd1,  8'h11, 8'hFF, 8'h01},
    {8'd4,  8'h22, 8'hFF, 8'h01},
    {8'd16, 8'h33, 8'hFF, 8'h01},
    {8'd40, 8'h44, 8'hFF, 8'h01},
    {8'd0,  8'h99, 8'hFF, 8'h01},
    {8'd8,  8'h55, 8'd0,  8'h00},
    {8'd8,  8'h66, 8'd9,  8'h00},
    {8'd20, 8'h77, 8'd23, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic done0, ok0, done1, ok1;
  int n_chk = 0, n_fail = 0;
  logic [7:0] fbuf [0:63];
  int flen;

  always #(TCK/2) clk = ~clk;

  one_pass_crc_checker u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .chk_done(done0), .chk_ok(ok0));

  one_pass_crc_checker #(.PRESET(ALT_PRESET), .RESIDUE(32'h0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .chk_done(done1), .chk_ok(ok1));

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bit-serial model: one wire bit at a time, LSB of each byte first.
  function automatic logic [31:0] model_crc(input logic [31:0] seed, input int n);
    logic [31:0] c = seed;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ fbuf[i][b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ RPOLY;
      end
    return c;
  endfunction

  task automatic build(input int len, input logic [7:0] seed, input logic [31:0] pre, input logic inv);
    logic [31:0] f;
    for (int k = 0; k < len; k++) fbuf[k] = 8'((int'(seed) * 37) + k * 13 + (k >> 2));
    f = model_crc(pre, len);
    if (inv) f = ~f;
    for (int j = 0; j < 4; j++) fbuf[len + j] = f[8*j +: 8];
    flen = len + 4;
  endtask

  task automatic drive(input logic v, input logic s, input logic e, input logic [7:0] d);
    @(negedge clk);
    in_valid = v; in_sof = s; in_eof = e; in_data = d;
  endtask

  task automatic send(input logic gaps);
    for (int i = 0; i < flen; i++) begin
      drive(1'b1, i == 0, i == flen - 1, fbuf[i]);
      if (gaps && i != flen - 1 && (i % 2 == 0)) drive(1'b0, 1'b0, 1'b0, 8'hA5);
    end
  endtask

  task automatic verdict(input logic which, input logic exp_ok, input string tag);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    check((which ? done1 : done0) == 1'b1, {tag, " done"}, which ? done1 : done0, 1);
    check((which ? ok1 : ok0) == exp_ok, {tag, " ok"}, which ? ok1 : ok0, exp_ok);
    @(negedge clk);
    check((which ? done1 : done0) == 1'b0, "R4 strobe width", which ? done1 : done0, 0);
  endtask

  initial begin
    #(TCK * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done0 == 1'b0 && ok0 == 1'b0, "R1 reset outputs", done0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done0 == 1'b0, "R1 idle after reset", done0, 0);

    // Vector table: R2 good frames, R3 corrupted frames
    for (int v = 0; v < 8; v++) begin
      build(int'(VECS[v][31:24]), VECS[v][23:16], 32'hFFFFFFFF, 1'b1);
      if (VECS[v][15:8] != 8'hFF) fbuf[VECS[v][15:8]] ^= 8'h04;
      send(1'b0);
      verdict(1'b0, VECS[v][0], VECS[v][0] ? "R2 vector" : "R3 vector");
    end

    // R2: known string with its published check value, low byte first
    flen = 13;
    for (int k = 0; k < 9; k++) fbuf[k] = 8'h31 + 8'(k);
    fbuf[9] = 8'h26; fbuf[10] = 8'h39; fbuf[11] = 8'hF4; fbuf[12] = 8'hCB;
    send(1'b0);
    verdict(1'b0, 1'b1, "R2 known string");

    // R5: gaps inside a good frame
    build(12, 8'h3C, 32'hFFFFFFFF, 1'b1);
    send(1'b1);
    verdict(1'b0, 1'b1, "R5 gapped frame");

    // R6: unfinished frame, then a restart with a good frame
    for (int k = 0; k < 5; k++) drive(1'b1, k == 0, 1'b0, 8'hE0 + 8'(k));
    build(10, 8'h5D, 32'hFFFFFFFF, 1'b1);
    send(1'b0);
    verdict(1'b0, 1'b1, "R6 restart");

    // R7: stray bytes and a stray end-of-frame outside any frame
    drive(1'b1, 1'b0, 1'b0, 8'h12);
    drive(1'b1, 1'b0, 1'b1, 8'h34);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    check(done0 == 1'b0, "R7 no stray strobe", done0, 0);
    @(negedge clk);
    check(done0 == 1'b0, "R7 still quiet", done0, 0);
    build(6, 8'h6E, 32'hFFFFFFFF, 1'b1);
    send(1'b0);
    verdict(1'b0, 1'b1, "R7 next frame clean");

    // R8: zero byte prepended to a frame computed over the message only
    build(7, 8'h7F, 32'hFFFFFFFF, 1'b1);
    for (int k = flen; k > 0; k--) fbuf[k] = fbuf[k-1];
    fbuf[0] = 8'h00; flen++;
    send(1'b0);
    verdict(1'b0, 1'b0, "R8 leading zero");

    // R9: zero byte appended after the CRC field
    build(7, 8'h80, 32'hFFFFFFFF, 1'b1);
    fbuf[flen] = 8'h00; flen++;
    send(1'b0);
    verdict(1'b0, 1'b0, "R9 trailing zero");

    // R10: zero residue, non-inverted CRC, other preset
    build(9, 8'h91, ALT_PRESET, 1'b0);
    send(1'b0);
    verdict(1'b1, 1'b1, "R10 zero residue good");
    build(9, 8'h92, ALT_PRESET, 1'b0);
    fbuf[3] ^= 8'h40;
    send(1'b0);
    verdict(1'b1, 1'b0, "R10 zero residue bad");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule